// File: doc/BRIEF.md
# Memory-Mapped ATA Buffer Window

This block lets a host reach an ATA-style storage device with ordinary memory reads and writes instead of I/O cycles. The host address space it decodes has two regions. One is a small task file of eight word registers, whose top register is written as a command and read as status. The other is a data port of 256 word addresses, where every address reaches the same sequential data stream. Behind the data port sits a 512-word buffer. It is split into two 256-word halves that are used in ping-pong fashion, so one side can fill one half while the other side empties the other half.

A command selects the transfer direction. When data flows toward the media, the host writes words into the data port. The block tells the media side that a half is ready once that half holds 256 words. The media side then reads the half back in the exact order the host wrote it. When data flows toward the host, the media side writes whole halves and the host reads them out through the data port. Each completed half raises an interrupt request. The host clears the interrupt by reading status or by issuing a new command. Host reads return data on a fixed three-clock latency. Media-side reads return data on the clock after the request.

Top module: `mata_window`

## Requirements
- R1: After reset, `irq`, `hst_rvalid` and `med_avail` are low, the direction is toward the media, and the status register reads 0x0008 (DRQ set, BSY clear).
- R2: Address bit 8 set selects the data port, whatever the low 8 bits are. Bit 8 clear with bits 7:3 zero selects task file register bits 2:0. Registers 0 to 6 read back the last value written to them. Any other address reads 0, and writes to it have no effect.
- R3: A host read presented in cycle c has `hst_rvalid` high and its data on `hst_rdata` in cycle c+3, with `hst_rvalid` low in cycles c+1 and c+2. A host write takes effect at the clock edge that samples it.
- R4: Toward the media, `med_avail` stays low until a half holds 256 host-written words. It goes high in the cycle after the 256th word is written, and stays high while a filled half remains undrained.
- R5: Toward the media, each accepted media read (`med_req` high, `med_we` low) returns on `med_rdata` in the next cycle the next word of the current half. Words come out in the order the host wrote them, half after half.
- R6: Toward the media, status bit 7 (BSY) is set and bit 3 (DRQ) is clear while both halves are full. A host data write made in that state is dropped, and neither the buffer contents nor the write position change.
- R7: Toward the host, 256 accepted media writes (`med_req` and `med_we` high) fill a half. The host then reads those words from the data port in the same order. `med_avail` is high exactly while the media-side half is empty.
- R8: A write to task file register 7 is a command. Bit 0 of the written value selects the direction: 0 is toward the media, 1 is toward the host. The command clears `irq`, empties both halves, resets both positions, and makes status read BSY set and DRQ clear in the cycle that follows.
- R9: `irq` rises in the cycle after a half completes on the media side: after the last media read of a half toward the media, or after the last media write of a half toward the host. Reading status (register 7) clears it, and data-port reads leave it unchanged.
- R10: Toward the host, while the host-side half is not full, status reads 0x0080, and a data-port read returns 0 without moving the read position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_req | input | 1 | Host access request for this cycle |
| hst_we | input | 1 | Host access is a write (1) or read (0) |
| hst_addr | input | 9 | Host word address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data |
| hst_rvalid | output | 1 | Host read data valid, three cycles after the request |
| med_req | input | 1 | Media-side access request |
| med_we | input | 1 | Media-side access is a write (1) or read (0) |
| med_wdata | input | 16 | Media-side write data |
| med_rdata | output | 16 | Media-side read data, valid the cycle after an accepted read |
| med_avail | output | 1 | A half is ready for the media side |
| irq | output | 1 | Interrupt request to the host |

## Verification
The bench builds the block with its default parameters: 16-bit words, 256-word halves, eight task file registers and a read latency of three. At these sizes the exact half-full boundary at the 255th and 256th word can be reached directly, and so can the state where both halves are full and the host is locked out. A randomly interleaved phase of host writes and media reads crosses the ping-pong boundary many times. Because the latency is three, the bench also confirms that `hst_rvalid` stays low for the two cycles between request and data on every read.

// File: rtl/ata_win_pkg.sv
package ata_win_pkg;

   typedef enum logic {
      DIR_TO_MEDIA = 1'b0,
      DIR_TO_HOST  = 1'b1
   } xfer_dir_e;

   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_TASK = 2'd1,
      WIN_DATA = 2'd2
   } win_e;

   localparam int STAT_BSY_BIT = 7;
   localparam int STAT_DRQ_BIT = 3;

   function automatic logic [7:0] pack_status(input logic bsy, input logic drq);
      logic [7:0] s;
      s = '0;
      s[STAT_BSY_BIT] = bsy;
      s[STAT_DRQ_BIT] = drq;
      return s;
   endfunction

endpackage

// File: rtl/atw_decode.sv
module atw_decode
   import ata_win_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int IDX_W  = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output win_e              win,
   output logic [IDX_W-1:0]  idx
);

   logic upper_zero;

   generate
      if (ADDR_W - 1 > IDX_W) begin : g_gap
         assign upper_zero = (addr[ADDR_W-2:IDX_W] == '0);
      end else begin : g_nogap
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign idx = addr[IDX_W-1:0];

   always_comb begin
      if (addr[ADDR_W-1])   win = WIN_DATA;
      else if (upper_zero)  win = WIN_TASK;
      else                  win = WIN_NONE;
   end

endmodule

// File: rtl/atw_dpram.sv
module atw_dpram #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 512
) (
   input  logic                     clk,
   input  logic                     a_we,
   input  logic [$clog2(DEPTH)-1:0] a_addr,
   input  logic [DATA_W-1:0]        a_wdata,
   output logic [DATA_W-1:0]        a_rdata,
   input  logic                     b_we,
   input  logic [$clog2(DEPTH)-1:0] b_addr,
   input  logic [DATA_W-1:0]        b_wdata,
   output logic [DATA_W-1:0]        b_rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (a_we) mem[a_addr] <= a_wdata;
      if (b_we) mem[b_addr] <= b_wdata;
      a_rdata <= mem[a_addr];
      b_rdata <= mem[b_addr];
   end

endmodule

// File: rtl/atw_occ.sv
module atw_occ
   import ata_win_pkg::*;
#(
   parameter int PTR_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_go,
   input  xfer_dir_e        cmd_dir,
   input  logic             host_step,
   input  logic             media_step,
   output xfer_dir_e        dir,
   output logic [PTR_W-1:0] hptr,
   output logic [PTR_W-1:0] mptr,
   output logic [1:0]       full,
   output logic             host_ok,
   output logic             media_ok,
   output logic             half_done,
   output logic             bsy,
   output logic             drq
);

   localparam int OFF_W = PTR_W - 1;

   logic cmd_busy;
   logic h_half, m_half;
   logic host_acc, media_acc, host_wrap, media_wrap;

   assign h_half = hptr[PTR_W-1];
   assign m_half = mptr[PTR_W-1];

   assign host_ok  = !cmd_busy &&
                     ((dir == DIR_TO_MEDIA) ? !full[h_half] : full[h_half]);
   assign media_ok = (dir == DIR_TO_MEDIA) ? full[m_half] : !full[m_half];

   assign host_acc   = host_step && host_ok;
   assign media_acc  = media_step && media_ok;
   assign host_wrap  = host_acc && (&hptr[OFF_W-1:0]);
   assign media_wrap = media_acc && (&mptr[OFF_W-1:0]);
   assign half_done  = media_wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir      <= DIR_TO_MEDIA;
         hptr     <= '0;
         mptr     <= '0;
         cmd_busy <= 1'b0;
      end else if (cmd_go) begin
         dir      <= cmd_dir;
         hptr     <= '0;
         mptr     <= '0;
         cmd_busy <= 1'b1;
      end else begin
         cmd_busy <= 1'b0;
         if (host_acc)  hptr <= hptr + PTR_W'(1);
         if (media_acc) mptr <= mptr + PTR_W'(1);
      end
   end

   generate
      for (genvar i = 0; i < 2; i++) begin : g_half
         logic q;
         logic fill_ev, drain_ev;
         assign fill_ev  = (dir == DIR_TO_MEDIA) ? (host_wrap && (h_half == 1'(i)))
                                                 : (media_wrap && (m_half == 1'(i)));
         assign drain_ev = (dir == DIR_TO_MEDIA) ? (media_wrap && (m_half == 1'(i)))
                                                 : (host_wrap && (h_half == 1'(i)));
         always_ff @(posedge clk) begin
            if (!rst_n)        q <= 1'b0;
            else if (cmd_go)   q <= 1'b0;
            else if (fill_ev)  q <= 1'b1;
            else if (drain_ev) q <= 1'b0;
         end
         assign full[i] = q;
      end
   endgenerate

   assign bsy = cmd_busy || ((dir == DIR_TO_MEDIA) ? (&full) : !full[h_half]);
   assign drq = !bsy;

endmodule

// File: rtl/atw_rdpipe.sv
module atw_rdpipe #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);

   generate
      if (STAGES == 0) begin : g_thru
         assign out_valid = in_valid;
         assign out_data  = in_data;
      end else begin : g_pipe
         logic [STAGES-1:0]        v;
         logic [STAGES-1:0][W-1:0] d;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v <= '0;
               d <= '0;
            end else begin
               v[0] <= in_valid;
               d[0] <= in_data;
               for (int s = 1; s < STAGES; s++) begin
                  v[s] <= v[s-1];
                  d[s] <= d[s-1];
               end
            end
         end
         assign out_valid = v[STAGES-1];
         assign out_data  = d[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mata_window.sv
module mata_window
   import ata_win_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int HALF_DEPTH = 256,
   parameter int TF_WORDS   = 8,
   parameter int RD_LAT     = 3,
   parameter int ADDR_W     = $clog2(HALF_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_req,
   input  logic              hst_we,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [DATA_W-1:0] hst_wdata,
   output logic [DATA_W-1:0] hst_rdata,
   output logic              hst_rvalid,
   input  logic              med_req,
   input  logic              med_we,
   input  logic [DATA_W-1:0] med_wdata,
   output logic [DATA_W-1:0] med_rdata,
   output logic              med_avail,
   output logic              irq
);

   localparam int IDX_W   = $clog2(TF_WORDS);
   localparam int PTR_W   = $clog2(HALF_DEPTH) + 1;
   localparam int DEPTH   = 2 * HALF_DEPTH;
   localparam int CMD_IDX = TF_WORDS - 1;
   localparam int NREG    = TF_WORDS - 1;

   generate
      if (HALF_DEPTH < 2 || (HALF_DEPTH & (HALF_DEPTH - 1)) != 0) begin : g_bad_half
         $error("HALF_DEPTH must be a power of two of at least 2");
      end
      if (TF_WORDS < 2 || (TF_WORDS & (TF_WORDS - 1)) != 0 || TF_WORDS >= HALF_DEPTH) begin : g_bad_tf
         $error("TF_WORDS must be a power of two, at least 2 and below HALF_DEPTH");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("RD_LAT must be at least 1");
      end
      if (DATA_W < 8) begin : g_bad_w
         $error("DATA_W must hold the 8-bit status");
      end
      if (ADDR_W != PTR_W) begin : g_bad_aw
         $error("ADDR_W must equal log2(HALF_DEPTH)+1");
      end
   endgenerate

   win_e              win;
   logic [IDX_W-1:0]  idx;
   xfer_dir_e         dir;
   logic [PTR_W-1:0]  hptr, mptr;
   logic [1:0]        full;
   logic              host_ok, media_ok, half_done, bsy, drq;
   logic              is_data, is_task, host_step, media_step;
   logic              cmd_go, status_rd, host_acc, media_acc;
   logic [DATA_W-1:0] mem_q, tf_rd, status_w;
   logic              s1_valid, s1_from_mem;
   logic [DATA_W-1:0] s1_val, s1_data;
   logic [DATA_W-1:0] tf_q [NREG];

   atw_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
      .addr (hst_addr),
      .win  (win),
      .idx  (idx)
   );

   assign is_data    = hst_req && (win == WIN_DATA);
   assign is_task    = hst_req && (win == WIN_TASK);
   assign host_step  = is_data && (hst_we == (dir == DIR_TO_MEDIA));
   assign media_step = med_req && (med_we == (dir == DIR_TO_HOST));
   assign cmd_go     = is_task && hst_we && (idx == IDX_W'(CMD_IDX));
   assign status_rd  = is_task && !hst_we && (idx == IDX_W'(CMD_IDX));
   assign host_acc   = host_step && host_ok;
   assign media_acc  = media_step && media_ok;

   atw_occ #(.PTR_W(PTR_W)) u_occ (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_go     (cmd_go),
      .cmd_dir    (hst_wdata[0] ? DIR_TO_HOST : DIR_TO_MEDIA),
      .host_step  (host_step),
      .media_step (media_step),
      .dir        (dir),
      .hptr       (hptr),
      .mptr       (mptr),
      .full       (full),
      .host_ok    (host_ok),
      .media_ok   (media_ok),
      .half_done  (half_done),
      .bsy        (bsy),
      .drq        (drq)
   );

   atw_dpram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
      .clk     (clk),
      .a_we    (host_acc && hst_we),
      .a_addr  (hptr),
      .a_wdata (hst_wdata),
      .a_rdata (mem_q),
      .b_we    (media_acc && med_we),
      .b_addr  (mptr),
      .b_wdata (med_wdata),
      .b_rdata (med_rdata)
   );

   assign med_avail = media_ok;

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_tf
         always_ff @(posedge clk) begin
            if (!rst_n)
               tf_q[r] <= '0;
            else if (is_task && hst_we && (idx == IDX_W'(r)))
               tf_q[r] <= hst_wdata;
         end
      end
   endgenerate

   always_comb begin
      tf_rd = '0;
      for (int r = 0; r < NREG; r++)
         if (idx == IDX_W'(r)) tf_rd = tf_q[r];
   end

   assign status_w = DATA_W'(pack_status(bsy, drq));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid    <= 1'b0;
         s1_from_mem <= 1'b0;
         s1_val      <= '0;
      end else begin
         s1_valid    <= hst_req && !hst_we;
         s1_from_mem <= host_acc && !hst_we;
         if (status_rd)              s1_val <= status_w;
         else if (is_task && !hst_we) s1_val <= tf_rd;
         else                         s1_val <= '0;
      end
   end

   assign s1_data = s1_from_mem ? mem_q : s1_val;

   atw_rdpipe #(.W(DATA_W), .STAGES(RD_LAT - 1)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (s1_valid),
      .in_data   (s1_data),
      .out_valid (hst_rvalid),
      .out_data  (hst_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         irq <= 1'b0;
      else if (cmd_go)    irq <= 1'b0;
      else if (half_done) irq <= 1'b1;
      else if (status_rd) irq <= 1'b0;
   end

endmodule

// File: rtl/mata_window_chk.sv
module mata_window_chk #(
   parameter int RD_LAT = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic       hst_req,
   input logic       hst_we,
   input logic       hst_rvalid,
   input logic       med_req,
   input logic       med_we,
   input logic       med_avail,
   input logic       irq,
   input logic       cmd_go,
   input logic       half_done,
   input logic [1:0] full,
   input logic       bsy,
   input logic       drq,
   input logic       dir
);

   logic [RD_LAT-1:0] lat_sr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_sr <= '0;
      end else begin
         lat_sr[0] <= hst_req && !hst_we;
         for (int i = 1; i < RD_LAT; i++) lat_sr[i] <= lat_sr[i-1];
      end
   end

   // R3: read valid appears exactly RD_LAT cycles after the request
   a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      hst_rvalid == lat_sr[RD_LAT-1]);

   // R8: a command leaves irq low in the next cycle
   a_r8_cmd_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |=> !irq);

   // R8: status shows busy right after a command
   a_r8_cmd_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |=> (bsy && !drq));

   // R9: irq only rises after a half completes on the media side
   a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(half_done));

   // R4: nothing offered to the media side while both halves are empty
   a_r4_no_avail_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir && full == 2'b00) |-> !med_avail);

   // R7: toward the host a half is filled only by a media write
   a_r7_fill_by_media: assert property (@(posedge clk) disable iff (!rst_n)
      (dir && $rose(full[0])) |-> $past(med_req && med_we));

endmodule

bind mata_window mata_window_chk #(.RD_LAT(RD_LAT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hst_req    (hst_req),
   .hst_we     (hst_we),
   .hst_rvalid (hst_rvalid),
   .med_req    (med_req),
   .med_we     (med_we),
   .med_avail  (med_avail),
   .irq        (irq),
   .cmd_go     (cmd_go),
   .half_done  (half_done),
   .full       (full),
   .bsy        (bsy),
   .drq        (drq),
   .dir        (dir)
);

// File: tb/tb_mata_window.sv
module tb_mata_window;

   localparam int DW  = 16;
   localparam int HD  = 256;
   localparam int TFW = 8;
   localparam int LAT = 3;
   localparam int AW  = 9;
   localparam logic [AW-1:0] CMD_ADDR = 9'h007;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          hst_req, hst_we;
   logic [AW-1:0] hst_addr;
   logic [DW-1:0] hst_wdata, hst_rdata;
   logic          hst_rvalid;
   logic          med_req, med_we;
   logic [DW-1:0] med_wdata, med_rdata;
   logic          med_avail, irq;

   always #4 clk = ~clk;

   mata_window #(.DATA_W(DW), .HALF_DEPTH(HD), .TF_WORDS(TFW), .RD_LAT(LAT)) dut (
      .clk(clk), .rst_n(rst_n),
      .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
      .med_req(med_req), .med_we(med_we), .med_wdata(med_wdata),
      .med_rdata(med_rdata), .med_avail(med_avail), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] exp_q[$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_status(input bit busy, input bit dreq);
      logic [DW-1:0] s;
      s = '0;
      s[7] = busy;
      s[3] = dreq;
      return s;
   endfunction

   function automatic logic [AW-1:0] data_addr();
      return {1'b1, 8'($urandom)};
   endfunction

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic host_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      hst_req = 1'b1; hst_we = 1'b1; hst_addr = a; hst_wdata = d;
      @(posedge clk);
      @(negedge clk);
      hst_req = 1'b0; hst_we = 1'b0;
   endtask

   task automatic host_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      logic early;
      hst_req = 1'b1; hst_we = 1'b0; hst_addr = a;
      @(posedge clk);
      @(negedge clk);
      hst_req = 1'b0;
      @(posedge clk);
      @(negedge clk);
      early = hst_rvalid;
      @(posedge clk);
      @(negedge clk);
      chk("R3 rvalid low before latency", 32'(early), 32'd0);
      chk("R3 rvalid at latency", 32'(hst_rvalid), 32'd1);
      d = hst_rdata;
   endtask

   task automatic med_rd(output logic [DW-1:0] d);
      med_req = 1'b1; med_we = 1'b0;
      @(posedge clk);
      @(negedge clk);
      med_req = 1'b0;
      d = med_rdata;
   endtask

   task automatic med_wr(input logic [DW-1:0] d);
      med_req = 1'b1; med_we = 1'b1; med_wdata = d;
      @(posedge clk);
      @(negedge clk);
      med_req = 1'b0; med_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] rd, w;
      logic [DW-1:0] tfv [TFW-1];
      int wcnt, mcnt, full_h;
      bit h_ok, m_ok;

      void'($urandom(32'd24681357));
      rst_n = 1'b0; hst_req = 1'b0; hst_we = 1'b0; hst_addr = '0; hst_wdata = '0;
      med_req = 1'b0; med_we = 1'b0; med_wdata = '0;
      idle(5);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 irq after reset", 32'(irq), 32'd0);
      chk("R1 rvalid after reset", 32'(hst_rvalid), 32'd0);
      chk("R1 med_avail after reset", 32'(med_avail), 32'd0);
      host_rd(CMD_ADDR, rd);
      chk("R1 status after reset", 32'(rd), 32'(exp_status(0, 1)));

      // R2: task file registers and unmapped space
      for (int i = 0; i < TFW - 1; i++) begin
         tfv[i] = 16'($urandom);
         host_wr(AW'(i), tfv[i]);
      end
      host_wr(9'h010, 16'hBEEF);
      host_wr(9'h0FF, 16'hCAFE);
      for (int i = 0; i < TFW - 1; i++) begin
         host_rd(AW'(i), rd);
         chk("R2 task register readback", 32'(rd), 32'(tfv[i]));
      end
      host_rd(9'h010, rd);
      chk("R2 unmapped read is zero", 32'(rd), 32'd0);
      host_rd(9'h0FF, rd);
      chk("R2 unmapped read is zero", 32'(rd), 32'd0);

      // R8: command toward media, busy for one cycle
      host_wr(CMD_ADDR, 16'h0000);
      host_rd(CMD_ADDR, rd);
      chk("R8 status busy right after command", 32'(rd), 32'(exp_status(1, 0)));
      host_rd(CMD_ADDR, rd);
      chk("R8 status ready after command", 32'(rd), 32'(exp_status(0, 1)));

      // R4: half-full threshold
      exp_q.delete();
      for (int i = 0; i < HD - 1; i++) begin
         w = 16'($urandom);
         exp_q.push_back(w);
         host_wr(data_addr(), w);
         if (($urandom % 4) == 0) idle(1);
      end
      chk("R4 no avail at 255 words", 32'(med_avail), 32'd0);
      w = 16'($urandom);
      exp_q.push_back(w);
      host_wr(data_addr(), w);
      chk("R4 avail at 256 words", 32'(med_avail), 32'd1);
      chk("R9 no irq on host fill", 32'(irq), 32'd0);

      // R6: both halves full
      for (int i = 0; i < HD; i++) begin
         w = 16'($urandom);
         exp_q.push_back(w);
         host_wr(data_addr(), w);
      end
      host_rd(CMD_ADDR, rd);
      chk("R6 status both halves full", 32'(rd), 32'(exp_status(1, 0)));
      host_wr(data_addr(), 16'hDEAD);
      chk("R4 avail held while half undrained", 32'(med_avail), 32'd1);

      // R5 / R9: drain first half
      for (int i = 0; i < HD; i++) begin
         if (i == HD - 1) chk("R9 irq low before half done", 32'(irq), 32'd0);
         med_rd(rd);
         chk("R5 media word order first half", 32'(rd), 32'(exp_q.pop_front()));
      end
      chk("R9 irq after half drained", 32'(irq), 32'd1);
      host_rd(CMD_ADDR, rd);
      chk("R6 status after one half drained", 32'(rd), 32'(exp_status(0, 1)));
      chk("R9 status read clears irq", 32'(irq), 32'd0);
      for (int i = 0; i < HD; i++) begin
         med_rd(rd);
         chk("R6 R5 second half intact", 32'(rd), 32'(exp_q.pop_front()));
      end
      chk("R4 no avail after drain", 32'(med_avail), 32'd0);

      // R4 / R5: random interleaving of host writes and media reads
      wcnt = 0; mcnt = 0;
      while (mcnt < 2 * HD) begin
         full_h = wcnt / HD - mcnt / HD;
         h_ok = (wcnt < 2 * HD) && (full_h < 2);
         m_ok = (full_h >= 1);
         chk("R4 avail tracks filled halves", 32'(med_avail), 32'(m_ok));
         if (h_ok && (!m_ok || ($urandom % 2) == 0)) begin
            w = 16'($urandom);
            exp_q.push_back(w);
            host_wr(data_addr(), w);
            wcnt++;
         end else begin
            med_rd(rd);
            chk("R5 mixed traffic order", 32'(rd), 32'(exp_q.pop_front()));
            mcnt++;
         end
      end

      // R8 / R10: command toward host
      host_wr(CMD_ADDR, 16'h0001);
      chk("R8 command clears irq", 32'(irq), 32'd0);
      chk("R7 avail with empty halves", 32'(med_avail), 32'd1);
      host_rd(data_addr(), rd);
      chk("R10 data read with no full half", 32'(rd), 32'd0);
      host_rd(CMD_ADDR, rd);
      chk("R10 status with no full half", 32'(rd), 32'(exp_status(1, 0)));

      // R7: media fills, host reads
      exp_q.delete();
      for (int i = 0; i < HD; i++) begin
         w = 16'($urandom);
         exp_q.push_back(w);
         med_wr(w);
         if (($urandom % 5) == 0) idle(1);
      end
      chk("R9 irq after media fill", 32'(irq), 32'd1);
      chk("R7 avail with second half free", 32'(med_avail), 32'd1);
      host_rd(data_addr(), rd);
      chk("R7 first host word", 32'(rd), 32'(exp_q.pop_front()));
      chk("R9 data read keeps irq", 32'(irq), 32'd1);
      for (int i = 0; i < HD; i++) begin
         w = 16'($urandom);
         exp_q.push_back(w);
         med_wr(w);
      end
      chk("R7 no avail with both halves full", 32'(med_avail), 32'd0);
      for (int i = 1; i < 2 * HD; i++) begin
         host_rd(data_addr(), rd);
         chk("R7 host read order", 32'(rd), 32'(exp_q.pop_front()));
      end
      host_rd(CMD_ADDR, rd);
      chk("R10 status after host emptied", 32'(rd), 32'(exp_status(1, 0)));
      host_rd(data_addr(), rd);
      chk("R10 empty read returns zero", 32'(rd), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule